// File: doc/BRIEF.md
# Word-Packed Byte FIFO Pair

This block joins a 32-bit register bus to a serial engine that moves one byte at a time. It holds two word queues. On the transmit side, software pushes 32-bit words and the block hands them to the engine one byte at a time. On the receive side, the engine delivers bytes and the block packs them into words that software pops. Each queue is `DEPTH` words deep, 8 by default.

Software sees three things. A status word packs the transmit free-slot count and the receive word count. A control word holds two programmable trigger levels and two flush bits that clear themselves. A flag vector carries the level-based data requests and the sticky overflow and underflow errors.

A message does not have to be a multiple of four bytes. A transmit word comes with a last-byte index, and only the bytes up to that index are sent. The engine can close a receive word early with an end marker. The unused upper bytes of that word then read as zero. Bytes sit little-endian in every word.

Top module: `wordfifo_pair`

## Requirements
- R1: After reset the status word is 0x80, the control read-back is 0xE0 (transmit trigger 7, receive trigger 0), the flag vector is 0x02, no engine byte is offered, and the engine receive side is ready.
- R2: Status bits 7:4 hold `DEPTH` minus the words waiting in the transmit queue. Status bits 3:0 hold the number of words waiting in the receive queue. A word already taken into the byte unpacker no longer counts as waiting.
- R3: A push while the transmit queue is full is dropped. It sets flag bit 5, which stays set until the next transmit flush.
- R4: A pop while the receive queue is empty returns 0. It sets flag bit 4, which stays set until the next receive flush.
- R5: Writing control bit 1 flushes the transmit side and writing control bit 0 flushes the receive side. The bit reads 1 in the cycle after the write, then 0 once the queue and any partial byte state are cleared.
- R6: Control bits 7:5 set the transmit trigger and bits 4:2 set the receive trigger. Both read back from the same positions.
- R7: Flag bit 1 (transmit request) is 1 exactly while the transmit free count is at least the transmit trigger plus one.
- R8: Flag bit 0 (receive request) is 1 exactly while the receive word count is at least the receive trigger plus one.
- R9: The unpacker sends byte 0 (bits 7:0) of each word first, then bits 15:8, and so on. It stops after the byte whose index equals the 2-bit last-byte index given with the push.
- R10: Received bytes fill a word from bits 7:0 upward. A word is queued after its fourth byte, or after a byte marked as the end, and in that case the bytes above it are zero.
- R11: An offered transmit byte stays valid and unchanged until the engine takes it. The receive side drops its ready while the receive queue is full.
- R12: Both queues keep words in first-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_tx_push | input | 1 | Push one word into the transmit queue |
| bus_tx_word | input | 32 | Word to push |
| bus_tx_last | input | 2 | Index of the last valid byte in the pushed word |
| bus_rx_pop | input | 1 | Pop one word from the receive queue |
| bus_rx_word | output | 32 | Head of the receive queue, 0 when empty |
| bus_ctl_wr | input | 1 | Control word write strobe |
| bus_ctl_wdata | input | 8 | Control write data: triggers and flush bits |
| bus_ctl_rdata | output | 8 | Control read-back: triggers and pending flush bits |
| bus_status | output | 8 | Transmit free count (7:4) and receive word count (3:0) |
| bus_flags | output | 6 | Bit 5 overflow, bit 4 underflow, bit 1 transmit request, bit 0 receive request |
| eng_tx_byte | output | 8 | Byte offered to the engine |
| eng_tx_valid | output | 1 | Byte offered |
| eng_tx_take | input | 1 | Engine takes the offered byte |
| eng_rx_byte | input | 8 | Byte from the engine |
| eng_rx_valid | input | 1 | Engine byte present |
| eng_rx_end | input | 1 | This byte closes the current word |
| eng_rx_ready | output | 1 | Block can accept an engine byte |

## Verification
Most internal faults surface on the first bus access after them, because the status word exposes both counts in the cycle after every push or pop. A pointer or count that has gone wrong misreports a level at once. It also flips the request flags at the wrong fill, and it sends bytes out of order on the next drain. A fault in the unpacker or packer shows up within one word: the bytes come out in the wrong order, too many are sent, or an early-closed receive word has non-zero upper bytes. A flush bit that does not clear itself, or an error flag that does not stick, can be seen in the control and flag read-back one cycle later.

// File: rtl/wpf_pkg.sv
package wpf_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_B   = 4;
    localparam int WORD_W   = BYTE_W * WORD_B;
    localparam int IDX_W    = $clog2(WORD_B);
    localparam int TRIG_W   = 3;

    // control word bit positions
    localparam int CTL_W        = 8;
    localparam int CTL_RX_FLUSH = 0;
    localparam int CTL_TX_FLUSH = 1;
    localparam int CTL_RX_TRIG  = 2;
    localparam int CTL_TX_TRIG  = 5;

    // flag vector bit positions
    localparam int FLG_W      = 6;
    localparam int FLG_RX_REQ = 0;
    localparam int FLG_TX_REQ = 1;
    localparam int FLG_RX_UNF = 4;
    localparam int FLG_TX_OVF = 5;

    localparam logic [TRIG_W-1:0] TX_TRIG_RST = 3'd7;
    localparam logic [TRIG_W-1:0] RX_TRIG_RST = 3'd0;

    typedef struct packed {
        logic [IDX_W-1:0]  last;
        logic [WORD_W-1:0] data;
    } txw_t;

    function automatic logic [BYTE_W-1:0] byte_of(input logic [WORD_W-1:0] w,
                                                  input logic [IDX_W-1:0] i);
        return w[i*BYTE_W +: BYTE_W];
    endfunction

    function automatic logic [WORD_W-1:0] place_byte(input logic [WORD_W-1:0] acc,
                                                     input logic [BYTE_W-1:0] b,
                                                     input logic [IDX_W-1:0] i);
        logic [WORD_W-1:0] r;
        r = acc;
        r[i*BYTE_W +: BYTE_W] = b;
        return r;
    endfunction

endpackage

// File: rtl/wpf_ring.sv
module wpf_ring #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rp];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R5
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/wpf_unpack.sv
module wpf_unpack
    import wpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  txw_t              head,
    input  logic              avail,
    output logic              pop,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    input  logic              take_i
);

    txw_t             cur;
    logic [IDX_W-1:0] idx;
    logic             busy;
    logic             take, fin, load;

    assign take    = busy && take_i;
    assign fin     = take && (idx == cur.last);
    assign load    = (!busy || fin) && avail && !flush;
    assign pop     = load;
    assign valid_o = busy;
    assign byte_o  = byte_of(cur.data, idx);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy <= 1'b0;
            idx  <= '0;
            cur  <= '0;
        end else if (load) begin
            cur  <= head;
            idx  <= '0;
            busy <= 1'b1;
        end else if (fin) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (take) begin
            idx  <= idx + IDX_W'(1);
        end
    end

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !take_i && !flush) |=> (valid_o && $stable(byte_o)));

endmodule

// File: rtl/wpf_pack.sv
module wpf_pack
    import wpf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              valid_i,
    input  logic              end_i,
    input  logic              room,
    output logic              ready_o,
    output logic              push_o,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] acc;
    logic [IDX_W-1:0]  bidx;
    logic              accept, done;

    assign ready_o = room;
    assign accept  = valid_i && room && !flush;
    assign done    = accept && (end_i || bidx == IDX_W'(WORD_B - 1));
    assign word_o  = place_byte(acc, byte_i, bidx);
    assign push_o  = done;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            acc  <= '0;
            bidx <= '0;
        end else if (done) begin
            acc  <= '0;
            bidx <= '0;
        end else if (accept) begin
            acc  <= word_o;
            bidx <= bidx + IDX_W'(1);
        end
    end

    // R11
    rx_room_chk: assert property (@(posedge clk) disable iff (rst)
        push_o |-> room);

endmodule

// File: rtl/wordfifo_pair.sv
module wordfifo_pair
    import wpf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_tx_push,
    input  logic [WORD_W-1:0] bus_tx_word,
    input  logic [IDX_W-1:0]  bus_tx_last,
    input  logic              bus_rx_pop,
    output logic [WORD_W-1:0] bus_rx_word,
    input  logic              bus_ctl_wr,
    input  logic [CTL_W-1:0]  bus_ctl_wdata,
    output logic [CTL_W-1:0]  bus_ctl_rdata,
    output logic [2*CW-1:0]   bus_status,
    output logic [FLG_W-1:0]  bus_flags,
    output logic [BYTE_W-1:0] eng_tx_byte,
    output logic              eng_tx_valid,
    input  logic              eng_tx_take,
    input  logic [BYTE_W-1:0] eng_rx_byte,
    input  logic              eng_rx_valid,
    input  logic              eng_rx_end,
    output logic              eng_rx_ready
);

    logic [TRIG_W-1:0] tx_trig, rx_trig;
    logic              tx_fl, rx_fl;
    logic              tx_ovf, rx_unf;

    txw_t              tx_in, tx_head;
    logic [CW-1:0]     tx_cnt, rx_cnt, tx_free;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_pop;
    logic              rx_push;
    logic [WORD_W-1:0] rx_in, rx_head;

    assign tx_in.data = bus_tx_word;
    assign tx_in.last = bus_tx_last;

    wpf_ring #(.W($bits(txw_t)), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(tx_fl),
        .push(bus_tx_push), .wdata(tx_in),
        .pop(tx_pop), .rdata(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    wpf_unpack u_unp (
        .clk(clk), .rst(rst), .flush(tx_fl),
        .head(tx_head), .avail(!tx_empty), .pop(tx_pop),
        .byte_o(eng_tx_byte), .valid_o(eng_tx_valid), .take_i(eng_tx_take)
    );

    wpf_ring #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(rx_fl),
        .push(rx_push), .wdata(rx_in),
        .pop(bus_rx_pop), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    wpf_pack u_pck (
        .clk(clk), .rst(rst), .flush(rx_fl),
        .byte_i(eng_rx_byte), .valid_i(eng_rx_valid), .end_i(eng_rx_end),
        .room(!rx_full), .ready_o(eng_rx_ready),
        .push_o(rx_push), .word_o(rx_in)
    );

    // control register: triggers persist, flush bits live one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_trig <= TX_TRIG_RST;
            rx_trig <= RX_TRIG_RST;
            tx_fl   <= 1'b0;
            rx_fl   <= 1'b0;
        end else if (bus_ctl_wr) begin
            tx_trig <= bus_ctl_wdata[CTL_TX_TRIG +: TRIG_W];
            rx_trig <= bus_ctl_wdata[CTL_RX_TRIG +: TRIG_W];
            tx_fl   <= bus_ctl_wdata[CTL_TX_FLUSH];
            rx_fl   <= bus_ctl_wdata[CTL_RX_FLUSH];
        end else begin
            tx_fl   <= 1'b0;
            rx_fl   <= 1'b0;
        end
    end

    // sticky errors, cleared by the matching flush
    always_ff @(posedge clk) begin
        if (rst || tx_fl)                  tx_ovf <= 1'b0;
        else if (bus_tx_push && tx_full)   tx_ovf <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || rx_fl)                  rx_unf <= 1'b0;
        else if (bus_rx_pop && rx_empty)   rx_unf <= 1'b1;
    end

    assign tx_free     = CW'(DEPTH) - tx_cnt;
    assign bus_status  = {tx_free, rx_cnt};
    assign bus_rx_word = rx_empty ? '0 : rx_head;

    always_comb begin
        bus_ctl_rdata                            = '0;
        bus_ctl_rdata[CTL_TX_TRIG +: TRIG_W]     = tx_trig;
        bus_ctl_rdata[CTL_RX_TRIG +: TRIG_W]     = rx_trig;
        bus_ctl_rdata[CTL_TX_FLUSH]              = tx_fl;
        bus_ctl_rdata[CTL_RX_FLUSH]              = rx_fl;
    end

    always_comb begin
        bus_flags             = '0;
        bus_flags[FLG_TX_OVF] = tx_ovf;
        bus_flags[FLG_RX_UNF] = rx_unf;
        bus_flags[FLG_TX_REQ] = (tx_free >= CW'(tx_trig) + CW'(1));
        bus_flags[FLG_RX_REQ] = (rx_cnt  >= CW'(rx_trig) + CW'(1));
    end

    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_tx_push && tx_full && !tx_fl) |=> bus_flags[FLG_TX_OVF]);

    // R4
    unf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rx_pop && rx_empty && !rx_fl) |=> bus_flags[FLG_RX_UNF]);

    // R5
    tx_flush_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_fl && !(bus_ctl_wr && bus_ctl_wdata[CTL_TX_FLUSH]))
            |=> (!bus_ctl_rdata[CTL_TX_FLUSH] && bus_status[2*CW-1:CW] == CW'(DEPTH)));

    // R5
    rx_flush_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_fl && !(bus_ctl_wr && bus_ctl_wdata[CTL_RX_FLUSH]))
            |=> (!bus_ctl_rdata[CTL_RX_FLUSH] && bus_status[CW-1:0] == '0));

endmodule

// File: tb/sim_wordfifo_pair.sv
module sim_wordfifo_pair;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_tx_push = 1'b0;
    logic [31:0] bus_tx_word = '0;
    logic [1:0]  bus_tx_last = '0;
    logic        bus_rx_pop = 1'b0;
    logic [31:0] bus_rx_word;
    logic        bus_ctl_wr = 1'b0;
    logic [7:0]  bus_ctl_wdata = '0;
    logic [7:0]  bus_ctl_rdata;
    logic [7:0]  bus_status;
    logic [5:0]  bus_flags;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_valid;
    logic        eng_tx_take = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_rx_valid = 1'b0;
    logic        eng_rx_end = 1'b0;
    logic        eng_rx_ready;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wordfifo_pair u0 (.*);

    // {last byte index, word}
    localparam logic [33:0] TBL [6] = '{
        {2'd3, 32'h44332211},
        {2'd2, 32'hA5C3_0F1E},
        {2'd0, 32'hFFFF_FF5A},
        {2'd1, 32'h8899_AABB},
        {2'd3, 32'hDEADBEEF},
        {2'd3, 32'h01020304}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_word(input logic [31:0] w, input logic [1:0] last);
        bus_tx_push = 1'b1; bus_tx_word = w; bus_tx_last = last;
        @(negedge clk);
        bus_tx_push = 1'b0;
    endtask

    task automatic ctl_write(input logic [7:0] v);
        bus_ctl_wr = 1'b1; bus_ctl_wdata = v;
        @(negedge clk);
        bus_ctl_wr = 1'b0;
    endtask

    task automatic rx_feed(input logic [7:0] b, input logic e);
        eng_rx_valid = 1'b1; eng_rx_byte = b; eng_rx_end = e;
        @(negedge clk);
        eng_rx_valid = 1'b0; eng_rx_end = 1'b0;
    endtask

    task automatic pop_check(input string req, input logic [31:0] exp);
        bus_rx_pop = 1'b1;
        check(req, bus_rx_word, exp);
        @(negedge clk);
        bus_rx_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        check("R1 status", {24'd0, bus_status}, 32'h80);
        check("R1 ctrl", {24'd0, bus_ctl_rdata}, 32'hE0);
        check("R1 flags", {26'd0, bus_flags}, 32'h02);
        check("R1 tx valid", {31'd0, eng_tx_valid}, 0);
        check("R1 rx ready", {31'd0, eng_rx_ready}, 1);

        // table walk, transmit side
        for (int i = 0; i < 6; i++) push_word(TBL[i][31:0], TBL[i][33:32]);
        check("R2 tx free", {28'd0, bus_status[7:4]}, 3);
        check("R11 first byte", {24'd0, eng_tx_byte}, 32'h11);
        step(2);
        check("R11 held byte", {24'd0, eng_tx_byte}, 32'h11);
        check("R11 held valid", {31'd0, eng_tx_valid}, 1);
        eng_tx_take = 1'b1;
        for (int i = 0; i < 6; i++) begin
            for (int k = 0; k <= int'(TBL[i][33:32]); k++) begin
                check("R9 valid", {31'd0, eng_tx_valid}, 1);
                check("R9 R12 byte", {24'd0, eng_tx_byte}, {24'd0, TBL[i][8*k +: 8]});
                step(1);
            end
        end
        check("R9 no extra byte", {31'd0, eng_tx_valid}, 0);
        eng_tx_take = 1'b0;

        // table walk, receive side
        for (int i = 0; i < 6; i++) begin
            for (int k = 0; k <= int'(TBL[i][33:32]); k++)
                rx_feed(TBL[i][8*k +: 8], k == int'(TBL[i][33:32]));
        end
        check("R2 rx count", {28'd0, bus_status[3:0]}, 6);
        for (int i = 0; i < 6; i++) begin
            pop_check("R10 R12 rx word",
                      TBL[i][31:0] & (32'hFFFFFFFF >> (8 * (3 - int'(TBL[i][33:32])))));
        end
        check("R2 rx drained", {28'd0, bus_status[3:0]}, 0);

        // overflow: one word in the unpacker, eight queued, one dropped
        for (int i = 0; i < 10; i++) push_word(32'h100 + 32'(i), 2'd3);
        check("R3 free zero", {28'd0, bus_status[7:4]}, 0);
        check("R3 ovf flag", {31'd0, bus_flags[5]}, 1);
        check("R7 tx req low", {31'd0, bus_flags[1]}, 0);
        step(2);
        check("R3 ovf sticky", {31'd0, bus_flags[5]}, 1);

        // transmit flush
        ctl_write(8'hE2);
        check("R5 tx flush pending", {31'd0, bus_ctl_rdata[1]}, 1);
        step(1);
        check("R5 tx flush done", {31'd0, bus_ctl_rdata[1]}, 0);
        check("R5 tx free full", {28'd0, bus_status[7:4]}, 8);
        check("R3 ovf cleared", {31'd0, bus_flags[5]}, 0);
        check("R5 tx idle", {31'd0, eng_tx_valid}, 0);

        // transmit trigger 3: request while free >= 4
        ctl_write(8'h60);
        check("R6 ctrl tx trig", {24'd0, bus_ctl_rdata}, 32'h60);
        for (int i = 0; i < 4; i++) push_word(32'h0, 2'd3);
        check("R7 free 5 req", {31'd0, bus_flags[1]}, 1);
        push_word(32'h0, 2'd3);
        check("R7 free 4 req", {31'd0, bus_flags[1]}, 1);
        push_word(32'h0, 2'd3);
        check("R7 free 3 no req", {31'd0, bus_flags[1]}, 0);
        ctl_write(8'h62);
        step(1);

        // receive trigger 1: request while count >= 2
        ctl_write(8'hE4);
        check("R6 ctrl rx trig", {24'd0, bus_ctl_rdata}, 32'hE4);
        for (int k = 0; k < 4; k++) rx_feed(8'(k), 1'b0);
        check("R8 one word no req", {31'd0, bus_flags[0]}, 0);
        for (int k = 0; k < 4; k++) rx_feed(8'(k), 1'b0);
        check("R8 two words req", {31'd0, bus_flags[0]}, 1);
        ctl_write(8'hE1);
        check("R5 rx flush pending", {31'd0, bus_ctl_rdata[0]}, 1);
        step(1);
        check("R5 rx flush done", {31'd0, bus_ctl_rdata[0]}, 0);
        check("R5 rx empty", {28'd0, bus_status[3:0]}, 0);

        // underflow
        pop_check("R4 empty pop zero", 32'h0);
        check("R4 unf flag", {31'd0, bus_flags[4]}, 1);
        ctl_write(8'hE1);
        step(1);
        check("R4 unf cleared", {31'd0, bus_flags[4]}, 0);

        // receive queue full
        for (int k = 0; k < 32; k++) rx_feed(8'(k), 1'b0);
        check("R11 rx full count", {28'd0, bus_status[3:0]}, 8);
        check("R11 rx not ready", {31'd0, eng_rx_ready}, 0);
        pop_check("R12 rx head", 32'h03020100);
        check("R11 rx ready again", {31'd0, eng_rx_ready}, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule